// File: doc/BRIEF.md
# Frame Header Inserting Packetizer

This block sits between a pixel byte source and a fixed-size endpoint FIFO. The source marks the first byte of each frame with a start flag and the last byte with an end flag. The block cuts the stream into packets of `PKT_BYTES` bytes and marks the final byte of every packet with a packet-end strobe. When a frame ends part way through a packet, the block closes that packet early as a short packet. A packet therefore never holds bytes from two frames.

Before the first pixel byte of each frame leaves the block, a complete header packet goes out. The header holds a 16-bit sync word, a running frame number and the number of pixel bytes emitted for the previous frame. The rest of the header packet is zero. A receiver uses the sync word to find frame boundaries and the byte count to check the length of the frame that has just ended.

The pixel source cannot be stalled, so the output uses valid/ready and a small FIFO absorbs bytes while the sink is not ready. If a byte arrives while the FIFO is full, the byte is dropped and a sticky overflow flag is set. If a new frame starts while a packet is still open because the end flag was missing, a sticky straddle flag is set.

Top module: `frame_hdr_packetizer`

## Requirements
- R1: After reset, `out_valid`, `overflow` and `straddle` are all 0.
- R2: When a byte carrying the start flag reaches the output, a header packet of exactly `PKT_BYTES` bytes is emitted first. Bytes 0 and 1 are the sync word, high byte first. Bytes 6 and up are 0x00. `out_last` is 1 only on byte `PKT_BYTES-1`.
- R3: Pixel bytes leave in arrival order. Without an end flag, `out_last` is 1 on every `PKT_BYTES`-th pixel byte of a packet and 0 on the others.
- R4: A pixel byte carrying the end flag is emitted with `out_last` = 1, closing a short packet. The next packet counts from zero again.
- R5: While `out_valid` is 1 and `out_ready` is 0, the block keeps `out_valid`, `out_data` and `out_last` unchanged in the next cycle.
- R6: While `out_ready` is 0, up to `FIFO_DEPTH` input bytes are held without loss and leave later in order.
- R7: An input byte arriving while `FIFO_DEPTH` bytes are already held is dropped and `overflow` becomes 1. `overflow` then stays 1 until reset.
- R8: If a header begins while a pixel packet is open (some bytes emitted, no `out_last` yet), `straddle` becomes 1 and stays 1 until reset. The open packet gets no `out_last`, and packet counting restarts after the header.
- R9: Header bytes 2 and 3 carry the frame number, high byte first. The first header after reset carries 0, and each later header carries one more, wrapping at 16 bits. Header bytes 4 and 5 carry, high byte first, the number of pixel bytes emitted since the previous header (0 for the first header).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input byte is present this cycle |
| in_data | input | 8 | Pixel byte |
| in_sof | input | 1 | The byte is the first of a frame |
| in_eof | input | 1 | The byte is the last of a frame |
| out_ready | input | 1 | The sink accepts a byte this cycle |
| out_valid | output | 1 | An output byte is offered |
| out_data | output | 8 | Header or pixel byte |
| out_last | output | 1 | Final byte of a full or short packet |
| overflow | output | 1 | Sticky: an input byte was dropped |
| straddle | output | 1 | Sticky: a frame started inside an open packet |

## Verification
A wrong packet counter appears on the very next packet as an `out_last` on the wrong byte, so the byte stream diverges from the arithmetic model within `PKT_BYTES` bytes. A wrong frame number or length counter appears in bytes 2 to 5 of the next header, one frame later. A FIFO pointer fault appears as reordered or repeated pixel bytes as soon as the FIFO wraps. The model is compared byte by byte over frame lengths from 1 to beyond twice the packet size, under three `out_ready` duty patterns, so each of these faults shows up within a few frames.

// File: rtl/pkt_pkg.sv
package pkt_pkg;

  // One buffered input byte with its frame markers.
  typedef struct packed {
    logic       sof;
    logic       eof;
    logic [7:0] data;
  } pix_t;

  // Header byte at position idx. The layout is fixed: sync word,
  // frame number, previous frame length (each high byte first),
  // then zero padding.
  function automatic logic [7:0] hdr_byte(input int unsigned idx,
                                          input logic [15:0] sync,
                                          input logic [15:0] fno,
                                          input logic [15:0] len);
    case (idx)
      0:       return sync[15:8];
      1:       return sync[7:0];
      2:       return fno[15:8];
      3:       return fno[7:0];
      4:       return len[15:8];
      5:       return len[7:0];
      default: return 8'h00;
    endcase
  endfunction

  // A pixel byte closes its packet when the packet is full or the frame ends.
  function automatic logic data_closes(input int unsigned cnt,
                                       input logic eof,
                                       input int unsigned pkt_bytes);
    return (cnt == pkt_bytes - 1) || eof;
  endfunction

endpackage

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop, drop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign drop    = push && full;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_push) wptr <= (wptr == LAST_PTR) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == LAST_PTR) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (drop) overflow <= 1'b1;
    end
  end

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> overflow); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R7
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop); // R6

endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
  import pkt_pkg::*;
#(
  parameter int          PKT_BYTES = 8,
  parameter logic [15:0] SYNC_WORD = 16'hA55A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  pix_t       head,
  input  logic       head_valid,
  input  logic       out_ready,
  output logic       pop,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last,
  output logic       straddle
);
  localparam int CW = $clog2(PKT_BYTES);
  localparam logic [CW-1:0] LAST_IDX = CW'(PKT_BYTES - 1);

  logic [CW-1:0] hdr_idx, pkt_cnt;
  logic [15:0]   frame_no, cur_len;
  logic          hdr_sent;

  // Named internal events used by the sequential logic and the assertions.
  logic hdr_pend, fire, hdr_fire, hdr_first, hdr_done, pkt_open;

  assign hdr_pend  = head_valid && head.sof && !hdr_sent;
  assign out_valid = head_valid;
  assign fire      = out_valid && out_ready;
  assign hdr_fire  = fire && hdr_pend;
  assign pop       = fire && !hdr_pend;
  assign hdr_first = hdr_fire && (hdr_idx == '0);
  assign hdr_done  = hdr_fire && (hdr_idx == LAST_IDX);
  assign pkt_open  = (pkt_cnt != '0);

  always_comb begin
    if (hdr_pend) begin
      out_data = hdr_byte(32'(hdr_idx), SYNC_WORD, frame_no, cur_len);
      out_last = (hdr_idx == LAST_IDX);
    end else begin
      out_data = head.data;
      out_last = data_closes(32'(pkt_cnt), head.eof, PKT_BYTES);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_idx  <= '0;
      pkt_cnt  <= '0;
      frame_no <= '0;
      cur_len  <= '0;
      hdr_sent <= 1'b0;
      straddle <= 1'b0;
    end else begin
      if (hdr_first && pkt_open) straddle <= 1'b1;
      if (hdr_fire) begin
        pkt_cnt <= '0;
        if (hdr_done) begin
          hdr_idx  <= '0;
          hdr_sent <= 1'b1;
          frame_no <= frame_no + 1'b1;
          cur_len  <= '0;
        end else begin
          hdr_idx <= hdr_idx + 1'b1;
        end
      end
      if (pop) begin
        hdr_sent <= 1'b0;
        cur_len  <= cur_len + 1'b1;
        pkt_cnt  <= out_last ? '0 : pkt_cnt + 1'b1;
      end
    end
  end

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R5
  AST_HDR_BEFORE_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && head.sof) |-> hdr_sent); // R2
  AST_STRADDLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_first && pkt_open) |=> straddle); // R8
  AST_STRADDLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    straddle |=> straddle); // R8
  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_done |=> (cur_len == '0)); // R9

endmodule

// File: rtl/frame_hdr_packetizer.sv
module frame_hdr_packetizer
  import pkt_pkg::*;
#(
  parameter int          PKT_BYTES  = 8,
  parameter int          FIFO_DEPTH = 8,
  parameter logic [15:0] SYNC_WORD  = 16'hA55A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last,
  output logic       overflow,
  output logic       straddle
);
  localparam int PW = $bits(pix_t);

  pix_t          in_pix, head_pix;
  logic [PW-1:0] head_bits;
  logic          fifo_empty, fifo_full, pop;

  assign in_pix   = '{sof: in_sof, eof: in_eof, data: in_data};
  assign head_pix = pix_t'(head_bits);

  pkt_fifo #(.W(PW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (in_valid),
    .push_data (in_pix),
    .pop       (pop),
    .head      (head_bits),
    .empty     (fifo_empty),
    .full      (fifo_full),
    .overflow  (overflow)
  );

  pkt_framer #(.PKT_BYTES(PKT_BYTES), .SYNC_WORD(SYNC_WORD)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .head       (head_pix),
    .head_valid (!fifo_empty),
    .out_ready  (out_ready),
    .pop        (pop),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_last   (out_last),
    .straddle   (straddle)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !overflow && !straddle)); // R1

endmodule

// File: tb/frame_hdr_packetizer_tb.sv
module frame_hdr_packetizer_tb;
  localparam int          P    = 6;
  localparam int          D    = 8;
  localparam logic [15:0] SYNC = 16'h5AC3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic       out_ready;
  logic       out_valid, out_last, overflow, straddle;
  logic [7:0] out_data;

  always #5 clk = ~clk;

  frame_hdr_packetizer #(.PKT_BYTES(P), .FIFO_DEPTH(D), .SYNC_WORD(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .overflow(overflow), .straddle(straddle));

  int checks = 0, fails = 0, mon_checks = 0, mon_fails = 0;
  int cyc = 0;
  int mode = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];

  // Arithmetic model state
  int m_fno = 0, m_len = 0, m_pcnt = 0;

  function automatic logic [7:0] model_hdr(int i, int fno, int len);
    if (i < 2) return 8'((SYNC >> (8 * (1 - i))) & 16'hFF);
    if (i < 4) return 8'((fno >> (8 * (3 - i))) & 255);
    if (i < 6) return 8'((len >> (8 * (5 - i))) & 255);
    return 8'h00;
  endfunction

  task automatic model_add(input logic [7:0] d, input logic sof, input logic eof);
    logic lst;
    if (sof) begin
      for (int i = 0; i < P; i++) begin
        exp_q.push_back({(i == P - 1), model_hdr(i, m_fno, m_len)});
        tag_q.push_back((i >= 2 && i < 6) ? "R9 header field" : "R2 header sync/pad/last");
      end
      m_fno  = (m_fno + 1) % 65536;
      m_len  = 0;
      m_pcnt = 0;
    end
    lst = (m_pcnt == P - 1) || eof;
    exp_q.push_back({lst, d});
    tag_q.push_back(eof ? "R4 short packet" : "R3 pixel packet");
    m_pcnt = lst ? 0 : m_pcnt + 1;
    m_len++;
  endtask

  task automatic push(input logic [7:0] d, input logic sof, input logic eof, input bit modeled);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = d; in_sof = sof; in_eof = eof;
    if (modeled) model_add(d, sof, eof);
    @(posedge clk); #1;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 4000) begin
      @(posedge clk); n++;
    end
    check(exp_q.size() == 0, "R3 all expected bytes emitted", exp_q.size(), 0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R3 no extra bytes after drain", out_valid, 0);
  endtask

  // Ready pattern, changed just after each rising edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    case (mode)
      0:       out_ready = 1'b1;
      1:       out_ready = cyc[0];
      2:       out_ready = (cyc % 3 == 0);
      default: out_ready = 1'b0;
    endcase
  end

  // Output monitor and hold check, sampled at the falling edge
  logic       stall_prev = 1'b0;
  logic [7:0] stall_d;
  logic       stall_l;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev) begin
        mon_checks++;
        if (!(out_valid && out_data == stall_d && out_last == stall_l)) begin
          mon_fails++;
          $display("FAIL R5 hold: actual %0d/%0h/%0d expected 1/%0h/%0d",
                   out_valid, out_data, out_last, stall_d, stall_l);
        end
      end
      stall_prev = out_valid && !out_ready;
      stall_d    = out_data;
      stall_l    = out_last;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          mon_fails++;
          $display("FAIL R3 unexpected byte: actual %0h expected none", out_data);
        end else begin
          logic [8:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          mon_checks++;
          if ({out_last, out_data} !== e) begin
            mon_fails++;
            $display("FAIL %s: actual last=%0d data=%0h expected last=%0d data=%0h",
                     t, out_last, out_data, e[8], e[7:0]);
          end
        end
      end
    end else begin
      stall_prev = 1'b0;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             checks + mon_checks, fails + mon_fails);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  initial begin
    mode = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: outputs idle while reset is asserted
    check(!out_valid && !overflow && !straddle, "R1 in reset",
          {out_valid, overflow, straddle}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(!out_valid && !overflow && !straddle, "R1 after reset",
          {out_valid, overflow, straddle}, 0);

    // R2 R3 R4 R9: sweep frame lengths under three ready duty patterns
    for (int m = 0; m < 3; m++) begin
      mode = m;
      for (int len = 1; len <= 2 * P + 1; len++) begin
        for (int i = 0; i < len; i++) begin
          push(8'((len * 16 + i * 7 + m) & 255), i == 0, i == len - 1, 1'b1);
          repeat (2) @(posedge clk);
        end
        repeat (24) @(posedge clk);
      end
      drain();
    end
    check(!overflow, "R6 no drop at moderate rate", overflow, 0);
    check(!straddle, "R8 no straddle with end flags", straddle, 0);

    // R8: a frame without an end flag, then a new frame
    mode = 1;
    for (int i = 0; i < 3; i++) push(8'(8'hE0 + i), i == 0, 1'b0, 1'b1);
    repeat (24) @(posedge clk);
    push(8'hEE, 1'b1, 1'b1, 1'b1);
    drain();
    check(straddle, "R8 straddle flag set", straddle, 1);

    // R6 R7: fill the FIFO while the sink is stalled, then overrun it
    mode = 3;
    repeat (3) @(posedge clk);
    for (int i = 0; i < D; i++) push(8'(8'h40 + i), i == 0, i == D - 1, 1'b1);
    @(negedge clk);
    check(!overflow, "R6 full FIFO without drop", overflow, 0);
    push(8'h99, 1'b0, 1'b0, 1'b0);
    push(8'h98, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check(overflow, "R7 overflow set on drop", overflow, 1);
    mode = 0;
    drain();
    check(overflow, "R7 overflow sticky", overflow, 1);
    check(straddle, "R8 straddle sticky", straddle, 1);
    summary();
  end

endmodule